// File: doc/BRIEF.md
# Programmable Trigger Line Generator

This block drives ten trigger lines, eight of the TTL class and two of the ECL class. Software changes the lines in two ways. A write to the command register can raise, lower or pulse any chosen group of lines. An interval timer can also pulse a programmed group of lines each time its count runs out.

All time keeping uses a single-cycle `tick` enable that arrives once every 100 ns. A pulse is stretched to a fixed width of 15 ticks. Each line output is the OR of its held level and its active pulse.

The timer has three registers: interval low half, interval high half and control. All three share one data offset. A 4-bit select value, held in its own register, decides which of the three that offset reaches. The timer registers can be read back through the same path. The line drivers themselves sit outside this block.

Top module: `trig_line_gen`

## Requirements
- R1: A command write with action bits 15:14 = 00 raises the held level of every line whose mask bit is 1. The mask is bits 7:0 for TTL lines 0..7 and bits 9:8 for ECL lines 0..1. Lines whose mask bit is 0 keep their state.
- R2: Action 01 lowers the held level of the masked lines. A raised line stays high until it is lowered this way or the block is reset.
- R3: A command with action 11 changes no line.
- R4: Action 10 starts a pulse on each masked line. The line is high right after the write. It goes low on the 15th tick after the write.
- R5: A pulse command, or a timer expiry, on a line that is already pulsing restarts its full 15-tick width.
- R6: Each line output is its held level OR its pulse. Lowering a line while it is pulsing keeps the line high until the pulse ends.
- R7: Writes at the timer data address go to one of three registers, chosen by the select register. Select 0000 reaches interval bits 15:0, 0001 reaches interval bits 31:16 and 1000 reaches control. Any other select value discards the write and reads back as 0.
- R8: Writing control bit 15 = 1 while the timer is stopped loads the counter from the interval. The first expiry falls on the N-th tick after that write, and later expiries follow every N ticks. Writing bit 15 = 0 stops the timer.
- R9: An interval below 20 ticks is treated as exactly 20.
- R10: Each expiry pulses exactly the lines set in control bits 9:0. A stopped timer pulses nothing.
- R11: After reset all lines are low and the select and timer registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable every 100 ns |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 command, 1 select, 2 timer data, 3 unused |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same coding as `wr_addr` |
| rd_data | output | 16 | Read data: the select value, the selected timer register, or 0 |
| trig_ttl | output | 8 | TTL-class trigger lines |
| trig_ecl | output | 2 | ECL-class trigger lines |

## Verification
A wrong held level appears on the line outputs in the cycle after the command write. A wrong pulse counter shows up as a pulse edge one or more ticks away from tick 15, so every pulse test counts ticks one at a time and samples the line after each tick near the edge. A wrong timer count or wrong reload moves the first expiry, or a later one, off its expected tick. The bench therefore samples around both the first and the second expiry, including the raised-to-20 case. Routing faults in the select path are checked by reading back all three timer registers after writes at valid and at reserved select values.

// File: rtl/trig_gen_pkg.sv
package trig_gen_pkg;
    typedef enum logic [1:0] {
        ACT_RAISE = 2'b00,
        ACT_LOWER = 2'b01,
        ACT_PULSE = 2'b10,
        ACT_NONE  = 2'b11
    } trig_act_e;

    localparam logic [1:0] ADR_CMD = 2'd0;
    localparam logic [1:0] ADR_SEL = 2'd1;
    localparam logic [1:0] ADR_TMR = 2'd2;

    localparam logic [3:0] SEL_IVL_LO = 4'b0000;
    localparam logic [3:0] SEL_IVL_HI = 4'b0001;
    localparam logic [3:0] SEL_CTRL   = 4'b1000;

    localparam int CTRL_EN_BIT = 15;
endpackage

// File: rtl/trig_cmd_decode.sv
module trig_cmd_decode
    import trig_gen_pkg::*;
#(
    parameter int NL = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic [15:0]   cmd_data,
    output logic [NL-1:0] raise_m,
    output logic [NL-1:0] lower_m,
    output logic [NL-1:0] pulse_m
);
    trig_act_e act;

    always_comb begin
        act     = trig_act_e'(cmd_data[15:14]);
        raise_m = '0;
        lower_m = '0;
        pulse_m = '0;
        if (cmd_we) begin
            case (act)
                ACT_RAISE: raise_m = cmd_data[NL-1:0];
                ACT_LOWER: lower_m = cmd_data[NL-1:0];
                ACT_PULSE: pulse_m = cmd_data[NL-1:0];
                default:   ;
            endcase
        end
    end

    // R3: the reserved action produces no strobe at all
    a_r3_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_data[15:14] == 2'b11) |-> (raise_m == '0 && lower_m == '0 && pulse_m == '0));

    // R1/R2: raise and lower never hit the same line together
    a_r1_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_m & lower_m) == '0);
endmodule

// File: rtl/trig_line.sv
module trig_line #(
    parameter int PULSE_TICKS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raise,
    input  logic lower,
    input  logic pulse,
    output logic line_out
);
    localparam int CW = $clog2(PULSE_TICKS + 1);

    typedef struct packed {
        logic          level;
        logic [CW-1:0] cnt;
    } line_st_t;

    line_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raise)
            st_d.level = 1'b1;
        else if (lower)
            st_d.level = 1'b0;
        if (pulse)
            st_d.cnt = CW'(PULSE_TICKS);
        else if (tick && st_q.cnt != '0)
            st_d.cnt = st_q.cnt - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign line_out = st_q.level | (st_q.cnt != '0);

    // R2: the held level moves only on a raise or lower strobe
    a_r2_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!raise && !lower) |=> $stable(st_q.level));

    // R5: a pulse strobe always starts a full-width count
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> (st_q.cnt == CW'(PULSE_TICKS)));

    // R4: the width counter steps down by one on each tick
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pulse && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - CW'(1)));
endmodule

// File: rtl/trig_interval_timer.sv
module trig_interval_timer
    import trig_gen_pkg::*;
#(
    parameter int NL           = 10,
    parameter int TMR_W        = 32,
    parameter int MIN_INTERVAL = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          tmr_we,
    input  logic [3:0]    sel,
    input  logic [15:0]   wr_data,
    output logic [15:0]   rd_data,
    output logic [NL-1:0] fire_m
);
    localparam int HALF = TMR_W / 2;

    typedef struct packed {
        logic [HALF-1:0]  ivl_lo;
        logic [HALF-1:0]  ivl_hi;
        logic             en;
        logic [NL-1:0]    mask;
        logic [TMR_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic [TMR_W-1:0] ivl, eff;
    logic expire;

    always_comb begin
        ivl = {st_q.ivl_hi, st_q.ivl_lo};
        eff = (ivl < TMR_W'(MIN_INTERVAL)) ? TMR_W'(MIN_INTERVAL) : ivl;
    end

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (st_q.en && tick) begin
            if (st_q.cnt <= TMR_W'(1)) begin
                expire   = 1'b1;
                st_d.cnt = eff;
            end else begin
                st_d.cnt = st_q.cnt - TMR_W'(1);
            end
        end
        if (tmr_we) begin
            case (sel)
                SEL_IVL_LO: st_d.ivl_lo = wr_data[HALF-1:0];
                SEL_IVL_HI: st_d.ivl_hi = wr_data[HALF-1:0];
                SEL_CTRL: begin
                    st_d.en   = wr_data[CTRL_EN_BIT];
                    st_d.mask = wr_data[NL-1:0];
                    if (wr_data[CTRL_EN_BIT] && !st_q.en)
                        st_d.cnt = eff;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign fire_m = expire ? st_q.mask : '0;

    always_comb begin
        rd_data = '0;
        case (sel)
            SEL_IVL_LO: rd_data[HALF-1:0] = st_q.ivl_lo;
            SEL_IVL_HI: rd_data[HALF-1:0] = st_q.ivl_hi;
            SEL_CTRL: begin
                rd_data[CTRL_EN_BIT] = st_q.en;
                rd_data[NL-1:0]      = st_q.mask;
            end
            default: ;
        endcase
    end

    // R9: a running counter never holds zero
    a_r9_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.en |-> (st_q.cnt != '0));

    // R8: an expiry reloads the counter with the raised interval
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !tmr_we) |=> (st_q.cnt == $past(eff)));

    // R10: a stopped timer fires nothing
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en) |-> (fire_m == '0));
endmodule

// File: rtl/trig_line_gen.sv
module trig_line_gen
    import trig_gen_pkg::*;
#(
    parameter int NUM_TTL      = 8,
    parameter int NUM_ECL      = 2,
    parameter int PULSE_TICKS  = 15,
    parameter int TMR_W        = 32,
    parameter int MIN_INTERVAL = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [15:0]        wr_data,
    input  logic [1:0]         rd_addr,
    output logic [15:0]        rd_data,
    output logic [NUM_TTL-1:0] trig_ttl,
    output logic [NUM_ECL-1:0] trig_ecl
);
    localparam int NL = NUM_TTL + NUM_ECL;

    typedef struct packed {
        logic [3:0] sel;
    } top_st_t;

    top_st_t st_d, st_q;
    logic [NL-1:0] raise_m, lower_m, pulse_m, fire_m, lines;
    logic [15:0]   tmr_rd;
    logic          cmd_we, tmr_we;

    always_comb begin
        cmd_we = wr_en && (wr_addr == ADR_CMD);
        tmr_we = wr_en && (wr_addr == ADR_TMR);
        st_d   = st_q;
        if (wr_en && wr_addr == ADR_SEL)
            st_d.sel = wr_data[3:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    trig_cmd_decode #(.NL(NL)) u_dec (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(wr_data),
        .raise_m(raise_m), .lower_m(lower_m), .pulse_m(pulse_m)
    );

    trig_interval_timer #(.NL(NL), .TMR_W(TMR_W), .MIN_INTERVAL(MIN_INTERVAL)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tmr_we(tmr_we), .sel(st_q.sel),
        .wr_data(wr_data), .rd_data(tmr_rd), .fire_m(fire_m)
    );

    for (genvar i = 0; i < NL; i++) begin : g_line
        trig_line #(.PULSE_TICKS(PULSE_TICKS)) u_line (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .raise(raise_m[i]), .lower(lower_m[i]),
            .pulse(pulse_m[i] | fire_m[i]), .line_out(lines[i])
        );
    end

    assign trig_ttl = lines[NUM_TTL-1:0];
    assign trig_ecl = lines[NL-1:NUM_TTL];

    always_comb begin
        case (rd_addr)
            ADR_SEL: rd_data = {12'b0, st_q.sel};
            ADR_TMR: rd_data = tmr_rd;
            default: rd_data = '0;
        endcase
    end

    // R7: the select register changes only on a write to its own address
    a_r7_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADR_SEL) |=> $stable(st_q.sel));
endmodule

// File: tb/trig_line_gen_tb.sv
module trig_line_gen_tb;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [7:0]  trig_ttl;
    logic [1:0]  trig_ecl;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    trig_line_gen u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .trig_ttl(trig_ttl), .trig_ecl(trig_ecl)
    );

    function automatic logic [9:0] lines();
        return {trig_ecl, trig_ttl};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); rd_addr = a; #1; d = rd_data;
    endtask

    task automatic clean();
        wr(2'd1, 16'h0008); wr(2'd2, 16'h0000);
        wr(2'd0, 16'h43FF);
        ticks(16);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R11 lines", 32'(lines()), 32'h0);
        rd(2'd1, d); chk("R11 sel", 32'(d), 32'h0);
        rd(2'd2, d); chk("R11 ivl lo", 32'(d), 32'h0);
    endtask

    task automatic t_levels();
        wr(2'd0, 16'h00F0); chk("R1 raise", 32'(lines()), 32'h0F0);
        wr(2'd0, 16'h0303); chk("R1 raise ecl, others kept", 32'(lines()), 32'h3F3);
        wr(2'd0, 16'h4230); chk("R2 lower", 32'(lines()), 32'h1C3);
        ticks(40);          chk("R2 level held", 32'(lines()), 32'h1C3);
        wr(2'd0, 16'hC3FF); chk("R3 reserved ignored", 32'(lines()), 32'h1C3);
        ticks(16);          chk("R3 no pulse from reserved", 32'(lines()), 32'h1C3);
        wr(2'd0, 16'h43FF); chk("R2 lower all", 32'(lines()), 32'h0);
    endtask

    task automatic t_pulse();
        wr(2'd0, 16'h8201); chk("R4 pulse start", 32'(lines()), 32'h201);
        ticks(14);          chk("R4 high after 14", 32'(lines()), 32'h201);
        ticks(1);           chk("R4 low at 15", 32'(lines()), 32'h0);
        wr(2'd0, 16'h8004); ticks(10);
        wr(2'd0, 16'h8004); ticks(14);
        chk("R5 restarted width", 32'(lines()), 32'h004);
        ticks(1);           chk("R5 ends 15 after restart", 32'(lines()), 32'h0);
    endtask

    task automatic t_or();
        wr(2'd0, 16'h0010); wr(2'd0, 16'h8010); ticks(20);
        chk("R6 pulse on raised line", 32'(lines()), 32'h010);
        wr(2'd0, 16'h8010); wr(2'd0, 16'h4010); ticks(14);
        chk("R6 lowered while pulsing", 32'(lines()), 32'h010);
        ticks(1);           chk("R6 low after pulse", 32'(lines()), 32'h0);
    endtask

    task automatic t_select();
        logic [15:0] d;
        wr(2'd1, 16'h0000); wr(2'd2, 16'h1234);
        wr(2'd1, 16'h0001); wr(2'd2, 16'h0056);
        wr(2'd1, 16'h0008); wr(2'd2, 16'h0155);
        wr(2'd1, 16'h0003); wr(2'd2, 16'hFFFF);
        rd(2'd2, d); chk("R7 reserved reads 0", 32'(d), 32'h0);
        wr(2'd1, 16'h0000); rd(2'd2, d); chk("R7 lo", 32'(d), 32'h1234);
        wr(2'd1, 16'h0001); rd(2'd2, d); chk("R7 hi", 32'(d), 32'h0056);
        wr(2'd1, 16'h0008); rd(2'd2, d); chk("R7 ctrl", 32'(d), 32'h0155);
        ticks(30); chk("R10 stopped no pulse", 32'(lines()), 32'h0);
    endtask

    task automatic t_timer();
        wr(2'd1, 16'h0000); wr(2'd2, 16'd25);
        wr(2'd1, 16'h0001); wr(2'd2, 16'h0000);
        wr(2'd1, 16'h0008); wr(2'd2, 16'h8201);
        ticks(24); chk("R8 before first expiry", 32'(lines()), 32'h0);
        ticks(1);  chk("R10 first expiry mask", 32'(lines()), 32'h201);
        ticks(15); chk("R8 pulse over", 32'(lines()), 32'h0);
        ticks(9);  chk("R8 before second expiry", 32'(lines()), 32'h0);
        ticks(1);  chk("R8 second expiry", 32'(lines()), 32'h201);
        wr(2'd2, 16'h0000); ticks(15);
        chk("R10 stopped", 32'(lines()), 32'h0);
        ticks(40); chk("R10 stays quiet", 32'(lines()), 32'h0);
    endtask

    task automatic t_floor();
        wr(2'd1, 16'h0000); wr(2'd2, 16'd5);
        wr(2'd1, 16'h0008); wr(2'd2, 16'h8080);
        ticks(19); chk("R9 no expiry at 19", 32'(lines()), 32'h0);
        ticks(1);  chk("R9 expiry at 20", 32'(lines()), 32'h080);
        wr(2'd2, 16'h0000);
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_levels();  clean();
        t_pulse();   clean();
        t_or();      clean();
        t_select();  clean();
        t_timer();   clean();
        t_floor();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule